// File: doc/BRIEF.md
# Serial Input Interrupt Unit

This block turns the sampled inputs of a serial GPIO chain into interrupts. The inputs are grouped into bit-index banks; each bank holds one bit per port, so a pin is named by its bit index and its port number. Each time the shift controller completes a burst, it presents the new sample vector for every pin together with a one-cycle valid strobe.

For each pin, software selects a trigger type and a level polarity, and can enable, acknowledge and observe the pin. A pin raises its identity bit when it is enabled and has a pending condition. The single interrupt line is the OR of all identity bits, gated by a master enable. Software reaches the configuration through a word-wide register port: writes take effect on the next clock edge, and reads return data combinationally.

Top module: `sirq_unit`

## Requirements
- R1: After a synchronous active-low reset, every configuration bit, the sample history and every pending edge are zero. As a result, `ident_o` is zero, `irq_o` is low and every register reads as zero.
- R2: The register addresses, with NB bit-index banks (default 4) and b the bank, are as follows. Address 0 is the control word, with the master enable in bit 0. Addresses 1+b hold polarity. Addresses 1+NB+s, for s from 0 to 2*NB-1, are the trigger sets. Addresses 1+3*NB+b hold enable, 1+4*NB+b acknowledge and 1+5*NB+b identity. Within every per-bank register, bit position p is port p. Polarity, trigger, enable and control read back what was written.
- R3: A pin's 2-bit trigger code takes its low bit from trigger set b and its high bit from trigger set NB+b. Code 0 means level, 1 means either edge, 2 means falling edge and 3 means rising edge.
- R4: For a level-triggered pin, the pending condition is the latest sample XOR its polarity bit, so polarity 0 is active high and polarity 1 is active low. Acknowledge writes leave a level-triggered pin unchanged.
- R5: Edges are found by comparing each new burst sample with the previous burst sample of the same pin. The history is zero after reset, so a 1 in the first burst counts as a rising edge.
- R6: A detected edge on an edge-triggered pin sets a sticky pending bit. Writing 1 at that port's position in the bank's acknowledge register clears it. Writing 0 has no effect.
- R7: If an edge is detected in the same cycle as an acknowledge of that pin, the pin stays pending.
- R8: An identity bit is the pin's enable AND its pending condition. Edges are still recorded while a pin is disabled, and they appear as soon as the pin is enabled.
- R9: `irq_o` is high exactly when the master enable is set and at least one identity bit is set.
- R10: Acknowledge registers read as zero. Writes to identity registers are ignored. Unmapped addresses read as zero.
- R11: A sample strobe or a register write changes `ident_o` from the next clock edge. Without either, `ident_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a new burst sample is present |
| smp_data | input | NB*NP | Burst sample, bit b*NP+p is bank b, port p |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | NP | Register write data |
| reg_rdata | output | NP | Register read data (combinational) |
| ident_o | output | NB*NP | Identity bits, bit b*NP+p is bank b, port p |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Every pin is given its own trigger code, spread across the banks, so that all four codes are tried on every port, and each polarity is tried against all-zero, all-one and pseudo-random sample vectors. Sequences of pseudo-random bursts tell either-edge pins apart from single-direction pins, and they separate edge pins, which stay pending once set, from level pins, which follow the samples. Acknowledge patterns that cover half the ports show that only the pins written with a 1 and set to an edge trigger are cleared. An acknowledge given in the same cycle as a burst checks that a new edge takes precedence. Masking with the per-pin enable and with the master enable separates a condition that was recorded from one that is only reported.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
// Package: shared trigger encoding and register address layout.
// Assumes addresses are laid out as a function of the bank count only.
package sirq_pkg;

    typedef enum logic [1:0] {
        TRG_LEVEL = 2'd0,
        TRG_ANY   = 2'd1,
        TRG_FALL  = 2'd2,
        TRG_RISE  = 2'd3
    } trig_e;

    localparam int CTRL_ADDR = 0;

    function automatic int pol_base(input int nb);
        pol_base = 1;
    endfunction

    function automatic int trg_base(input int nb);
        trg_base = 1 + nb;
    endfunction

    function automatic int ena_base(input int nb);
        ena_base = 1 + 3 * nb;
    endfunction

    function automatic int ack_base(input int nb);
        ack_base = 1 + 4 * nb;
    endfunction

    function automatic int id_base(input int nb);
        id_base = 1 + 5 * nb;
    endfunction

    function automatic int reg_count(input int nb);
        reg_count = 1 + 6 * nb;
    endfunction

endpackage

// File: rtl/sirq_regfile.sv
`timescale 1ns/1ps
// Register file: holds the master enable and the per-bank polarity, trigger
// and enable words, decodes acknowledge strobes and serves reads.
// Assumes NP >= 2 and one write per cycle; reads are combinational.
module sirq_regfile
    import sirq_pkg::*;
#(
    parameter int NB = 4,
    parameter int NP = 32,
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [NP-1:0]    reg_wdata,
    output logic [NP-1:0]    reg_rdata,
    input  logic [NB*NP-1:0] ident_i,
    output logic             master_o,
    output logic [NB*NP-1:0] pol_o,
    output logic [NB*NP-1:0] trg_lo_o,
    output logic [NB*NP-1:0] trg_hi_o,
    output logic [NB*NP-1:0] ena_o,
    output logic [NB-1:0]    ack_we_o
);

    localparam int A_POL = pol_base(NB);
    localparam int A_TRG = trg_base(NB);
    localparam int A_ENA = ena_base(NB);
    localparam int A_ACK = ack_base(NB);
    localparam int A_ID  = id_base(NB);

    logic          master_q;
    logic [NP-1:0] pol_q [NB];
    logic [NP-1:0] trg_q [2*NB];
    logic [NP-1:0] ena_q [NB];

    // Purpose: capture configuration writes, clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            for (int b = 0; b < NB; b++) begin
                pol_q[b] <= '0;
                ena_q[b] <= '0;
            end
            for (int s = 0; s < 2 * NB; s++) begin
                trg_q[s] <= '0;
            end
        end else if (reg_we) begin
            if (reg_addr == AW'(CTRL_ADDR)) begin
                master_q <= reg_wdata[0];
            end
            for (int b = 0; b < NB; b++) begin
                if (reg_addr == AW'(A_POL + b)) pol_q[b] <= reg_wdata;
                if (reg_addr == AW'(A_ENA + b)) ena_q[b] <= reg_wdata;
            end
            for (int s = 0; s < 2 * NB; s++) begin
                if (reg_addr == AW'(A_TRG + s)) trg_q[s] <= reg_wdata;
            end
        end
    end

    // Purpose: one-cycle acknowledge strobe per bank.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            ack_we_o[b] = reg_we && (reg_addr == AW'(A_ACK + b));
        end
    end

    genvar gb;
    generate
        for (gb = 0; gb < NB; gb++) begin : g_flat
            assign pol_o[gb*NP +: NP]    = pol_q[gb];
            assign trg_lo_o[gb*NP +: NP] = trg_q[gb];
            assign trg_hi_o[gb*NP +: NP] = trg_q[NB + gb];
            assign ena_o[gb*NP +: NP]    = ena_q[gb];
        end
    endgenerate

    assign master_o = master_q;

    // Purpose: read multiplexer; acknowledge and unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(CTRL_ADDR)) begin
            reg_rdata = {{(NP-1){1'b0}}, master_q};
        end
        for (int b = 0; b < NB; b++) begin
            if (reg_addr == AW'(A_POL + b)) reg_rdata = pol_q[b];
            if (reg_addr == AW'(A_ENA + b)) reg_rdata = ena_q[b];
            if (reg_addr == AW'(A_ID + b))  reg_rdata = ident_i[b*NP +: NP];
        end
        for (int s = 0; s < 2 * NB; s++) begin
            if (reg_addr == AW'(A_TRG + s)) reg_rdata = trg_q[s];
        end
    end

endmodule

// File: rtl/sirq_pin_bank.sv
`timescale 1ns/1ps
// Pin bank: one bit index across NP ports. Keeps the last burst sample,
// detects edges against it, holds sticky edge-pending bits and forms identity.
// Assumes smp_valid is a single-cycle strobe per burst.
module sirq_pin_bank
    import sirq_pkg::*;
#(
    parameter int NP = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [NP-1:0] smp_vec,
    input  logic [NP-1:0] trg_lo,
    input  logic [NP-1:0] trg_hi,
    input  logic [NP-1:0] pol,
    input  logic [NP-1:0] ena,
    input  logic          ack_we,
    input  logic [NP-1:0] ack_mask,
    output logic [NP-1:0] ident
);

    logic [NP-1:0] cur_q;
    logic [NP-1:0] pend_q;
    logic [NP-1:0] evt;
    logic [NP-1:0] is_level;
    logic [NP-1:0] clr_mask;
    logic [NP-1:0] set_mask;

    genvar gp;
    generate
        for (gp = 0; gp < NP; gp++) begin : g_port
            logic rise;
            logic fall;
            assign rise = smp_vec[gp] & ~cur_q[gp];
            assign fall = ~smp_vec[gp] & cur_q[gp];

            // Purpose: select the edge event this port's trigger code asks for.
            always_comb begin
                case (trig_e'({trg_hi[gp], trg_lo[gp]}))
                    TRG_ANY:  evt[gp] = rise | fall;
                    TRG_FALL: evt[gp] = fall;
                    TRG_RISE: evt[gp] = rise;
                    default:  evt[gp] = 1'b0;
                endcase
            end

            assign is_level[gp] = ({trg_hi[gp], trg_lo[gp]} == TRG_LEVEL);
        end
    endgenerate

    assign clr_mask = ack_we ? ack_mask : '0;
    assign set_mask = smp_valid ? evt : '0;

    // Purpose: update sample history and sticky edge state; a new edge beats an ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            pend_q <= '0;
        end else begin
            if (smp_valid) cur_q <= smp_vec;
            pend_q <= (pend_q & ~clr_mask) | set_mask;
        end
    end

    // Purpose: identity is enable AND (level condition or sticky edge).
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            ident[p] = ena[p] & (is_level[p] ? (cur_q[p] ^ pol[p]) : pend_q[p]);
        end
    end

endmodule

// File: rtl/sirq_unit.sv
`timescale 1ns/1ps
// Top: serial input interrupt unit. One register file and NB pin banks;
// the interrupt line is the OR of all identity bits gated by master enable.
// Assumes a single clock domain with the shift controller.
module sirq_unit
    import sirq_pkg::*;
#(
    parameter int NB = 4,
    parameter int NP = 32,
    parameter int AW = $clog2(reg_count(NB))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [NB*NP-1:0] smp_data,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [NP-1:0]    reg_wdata,
    output logic [NP-1:0]    reg_rdata,
    output logic [NB*NP-1:0] ident_o,
    output logic             irq_o
);

    logic             master_en;
    logic [NB*NP-1:0] pol_flat;
    logic [NB*NP-1:0] trg_lo_flat;
    logic [NB*NP-1:0] trg_hi_flat;
    logic [NB*NP-1:0] ena_flat;
    logic [NB-1:0]    ack_we;

    sirq_regfile #(.NB(NB), .NP(NP), .AW(AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ident_i   (ident_o),
        .master_o  (master_en),
        .pol_o     (pol_flat),
        .trg_lo_o  (trg_lo_flat),
        .trg_hi_o  (trg_hi_flat),
        .ena_o     (ena_flat),
        .ack_we_o  (ack_we)
    );

    genvar gb;
    generate
        for (gb = 0; gb < NB; gb++) begin : g_bank
            sirq_pin_bank #(.NP(NP)) bank_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .smp_valid (smp_valid),
                .smp_vec   (smp_data[gb*NP +: NP]),
                .trg_lo    (trg_lo_flat[gb*NP +: NP]),
                .trg_hi    (trg_hi_flat[gb*NP +: NP]),
                .pol       (pol_flat[gb*NP +: NP]),
                .ena       (ena_flat[gb*NP +: NP]),
                .ack_we    (ack_we[gb]),
                .ack_mask  (reg_wdata),
                .ident     (ident_o[gb*NP +: NP])
            );
        end
    endgenerate

    assign irq_o = master_en & (|ident_o);

endmodule

// File: rtl/sirq_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the interrupt unit, bound to the top.
// Assumes reset is asserted from time zero.
module sirq_chk #(
    parameter int NB = 4,
    parameter int NP = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             reg_we,
    input logic             master_en,
    input logic [NB*NP-1:0] ena_flat,
    input logic [NB*NP-1:0] ident_o,
    input logic             irq_o
);

    logic started = 1'b0;

    // Purpose: mark that one clock edge has passed.
    always_ff @(posedge clk) started <= 1'b1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        (started && !$past(rst_n)) |-> (ident_o == '0 && !irq_o));

    // R8
    ident_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_o & ~ena_flat) == '0);

    // R9
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> !irq_o);

    // R9
    quiet_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_o == '0) |-> !irq_o);

    // R11
    ident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(smp_valid) && !$past(reg_we)) |-> $stable(ident_o));

endmodule

bind sirq_unit sirq_chk #(.NB(NB), .NP(NP)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .reg_we    (reg_we),
    .master_en (master_en),
    .ena_flat  (ena_flat),
    .ident_o   (ident_o),
    .irq_o     (irq_o)
);

// File: tb/sirq_unit_tb_top.sv
`timescale 1ns/1ps
module sirq_unit_tb_top;

    localparam int NB = 4;
    localparam int NP = 32;
    localparam int AW = $clog2(1 + 6 * NB);
    localparam int A_POL = 1;
    localparam int A_TRG = 1 + NB;
    localparam int A_ENA = 1 + 3 * NB;
    localparam int A_ACK = 1 + 4 * NB;
    localparam int A_ID  = 1 + 5 * NB;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_valid = 1'b0;
    logic [NB*NP-1:0] smp_data = '0;
    logic             reg_we = 1'b0;
    logic [AW-1:0]    reg_addr = '0;
    logic [NP-1:0]    reg_wdata = '0;
    logic [NP-1:0]    reg_rdata;
    logic [NB*NP-1:0] ident_o;
    logic             irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sirq_unit #(.NB(NB), .NP(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ident_o(ident_o), .irq_o(irq_o)
    );

    // Spec model state
    logic          m_master;
    logic [NP-1:0] m_pol [NB];
    logic [NP-1:0] m_lo [NB];
    logic [NP-1:0] m_hi [NB];
    logic [NP-1:0] m_ena [NB];
    logic [NP-1:0] m_cur [NB];
    logic [NP-1:0] m_pend [NB];

    task automatic model_reset();
        m_master = 1'b0;
        for (int b = 0; b < NB; b++) begin
            m_pol[b] = '0; m_lo[b] = '0; m_hi[b] = '0;
            m_ena[b] = '0; m_cur[b] = '0; m_pend[b] = '0;
        end
    endtask

    function automatic logic [NB*NP-1:0] exp_ident();
        logic [NB*NP-1:0] r;
        r = '0;
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < NP; p++) begin
                logic act;
                if ({m_hi[b][p], m_lo[b][p]} == 2'd0) act = m_cur[b][p] ^ m_pol[b][p];
                else act = m_pend[b][p];
                r[b*NP+p] = m_ena[b][p] & act;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One stimulus cycle plus the model update that the requirements define.
    task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [NP-1:0] d,
                       input logic sv, input logic [NB*NP-1:0] sd);
        logic [NP-1:0] evt [NB];
        logic [NP-1:0] ackm [NB];
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; smp_valid = sv; smp_data = sd;
        @(negedge clk);
        reg_we = 1'b0; smp_valid = 1'b0;
        for (int b = 0; b < NB; b++) begin
            ackm[b] = '0;
            for (int p = 0; p < NP; p++) begin
                logic nw, od;
                nw = sd[b*NP+p]; od = m_cur[b][p];
                case ({m_hi[b][p], m_lo[b][p]})
                    2'd1: evt[b][p] = nw ^ od;
                    2'd2: evt[b][p] = od & ~nw;
                    2'd3: evt[b][p] = nw & ~od;
                    default: evt[b][p] = 1'b0;
                endcase
            end
        end
        if (we) begin
            if (a == AW'(0)) m_master = d[0];
            for (int b = 0; b < NB; b++) begin
                if (a == AW'(A_POL + b)) m_pol[b] = d;
                if (a == AW'(A_TRG + b)) m_lo[b] = d;
                if (a == AW'(A_TRG + NB + b)) m_hi[b] = d;
                if (a == AW'(A_ENA + b)) m_ena[b] = d;
                if (a == AW'(A_ACK + b)) ackm[b] = d;
            end
        end
        for (int b = 0; b < NB; b++) begin
            m_pend[b] = (m_pend[b] & ~ackm[b]) | (sv ? evt[b] : '0);
            if (sv) m_cur[b] = sd[b*NP +: NP];
        end
    endtask

    task automatic wr(input int a, input logic [NP-1:0] d);
        cyc(1'b1, AW'(a), d, 1'b0, '0);
    endtask

    task automatic smp(input logic [NB*NP-1:0] sd);
        cyc(1'b0, '0, '0, 1'b1, sd);
    endtask

    task automatic check_out(input string tag);
        logic [NB*NP-1:0] e;
        logic ei;
        e = exp_ident();
        ei = m_master & (|e);
        total++;
        if (ident_o !== e) begin
            bad++;
            $display("FAIL %s ident act=%h exp=%h", tag, ident_o, e);
        end
        total++;
        if (irq_o !== ei) begin
            bad++;
            $display("FAIL %s irq act=%b exp=%b", tag, irq_o, ei);
        end
    endtask

    task automatic rd_chk(input int a, input logic [NP-1:0] e, input string tag);
        reg_addr = AW'(a);
        #1;
        total++;
        if (reg_rdata !== e) begin
            bad++;
            $display("FAIL %s addr=%0d act=%h exp=%h", tag, a, reg_rdata, e);
        end
    endtask

    function automatic logic [NB*NP-1:0] rnd_vec(input logic [31:0] seed);
        logic [NB*NP-1:0] v;
        logic [31:0] s;
        s = seed;
        for (int b = 0; b < NB; b++) begin
            s = nxt(s);
            v[b*NP +: NP] = s;
        end
        return v;
    endfunction

    initial begin
        logic [31:0] seed;
        logic [NP-1:0] lo_w, hi_w;
        model_reset();
        do_reset();

        // R1: reset state
        check_out("R1 reset");
        rd_chk(0, '0, "R1 ctrl");
        for (int b = 0; b < NB; b++) begin
            rd_chk(A_POL + b, '0, "R1 pol");
            rd_chk(A_ENA + b, '0, "R1 ena");
            rd_chk(A_ID + b, '0, "R1 ident");
        end
        for (int s = 0; s < 2 * NB; s++) rd_chk(A_TRG + s, '0, "R1 trg");

        // R2: readback of every writable register
        wr(0, 32'h1);
        rd_chk(0, 32'h1, "R2 ctrl");
        for (int b = 0; b < NB; b++) begin
            wr(A_POL + b, 32'hA5A5_0000 ^ b);
            rd_chk(A_POL + b, 32'hA5A5_0000 ^ b, "R2 pol");
            wr(A_ENA + b, 32'h0F0F_F0F0 + b);
            rd_chk(A_ENA + b, 32'h0F0F_F0F0 + b, "R2 ena");
        end
        for (int s = 0; s < 2 * NB; s++) begin
            wr(A_TRG + s, 32'h1234_5670 + s);
            rd_chk(A_TRG + s, 32'h1234_5670 + s, "R2 trg");
        end

        // R10: ack reads zero, ident ignores writes, unmapped reads zero
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_chk(A_ACK, '0, "R10 ack read");
        wr(A_ID + 1, 32'hFFFF_FFFF);
        rd_chk(A_ID + 1, exp_ident()[NP +: NP], "R10 ident write");
        check_out("R10 ident write");
        rd_chk((1 << AW) - 1, '0, "R10 unmapped");

        // R4: level mode, polarity sweep
        do_reset();
        wr(0, 32'h1);
        for (int b = 0; b < NB; b++) begin
            wr(A_ENA + b, '1);
            wr(A_POL + b, (b % 2 == 0) ? 32'h0000_FFFF : 32'hFFFF_0000);
        end
        smp('0);
        check_out("R4 level zeros");
        smp('1);
        check_out("R4 level ones");
        seed = 32'hC0FF_EE01;
        for (int i = 0; i < 6; i++) begin
            seed = nxt(seed);
            smp(rnd_vec(seed));
            check_out("R4 R9 level random");
        end
        wr(A_ACK + 2, '1);
        check_out("R4 ack on level");

        // R3 R5 R6: mixed trigger codes, all four on every port
        do_reset();
        wr(0, 32'h1);
        for (int b = 0; b < NB; b++) begin
            lo_w = '0; hi_w = '0;
            for (int p = 0; p < NP; p++) begin
                lo_w[p] = ((p + b) % 4) & 1;
                hi_w[p] = ((p + b) % 4) >> 1;
            end
            wr(A_TRG + b, lo_w);
            wr(A_TRG + NB + b, hi_w);
            wr(A_ENA + b, '1);
        end
        smp('1);
        check_out("R5 first burst");
        for (int i = 0; i < 10; i++) begin
            seed = nxt(seed);
            smp(rnd_vec(seed));
            check_out("R3 R5 edge random");
            if (i % 3 == 2) begin
                wr(A_ACK + (i % NB), 32'h5555_5555);
                check_out("R6 half ack");
                wr(A_ACK + ((i + 1) % NB), 32'h0);
                check_out("R6 zero ack");
            end
        end
        for (int b = 0; b < NB; b++) begin
            wr(A_ACK + b, '1);
            check_out("R6 full ack");
        end

        // R7: edge and ack in the same cycle
        do_reset();
        wr(0, 32'h1);
        wr(A_TRG + 0, '1);
        wr(A_TRG + NB, '1);
        wr(A_ENA, '1);
        smp({{(NB-1)*NP{1'b0}}, 32'h0000_00FF});
        check_out("R7 setup");
        cyc(1'b1, AW'(A_ACK), '1, 1'b1, {{(NB-1)*NP{1'b0}}, 32'h0000_FFFF});
        check_out("R7 edge beats ack");
        total++;
        if (ident_o[15:8] !== 8'hFF || ident_o[7:0] !== 8'h00) begin
            bad++;
            $display("FAIL R7 act=%h exp=%h", ident_o[15:0], 16'hFF00);
        end

        // R8: disabled pin still records edges
        wr(A_ENA, '0);
        smp({{(NB-1)*NP{1'b0}}, 32'hFFFF_FFFF});
        check_out("R8 disabled");
        wr(A_ENA, 32'hFFFF_0000);
        check_out("R8 enable later");

        // R9: master gate
        wr(0, 32'h0);
        check_out("R9 master off");
        wr(0, 32'h1);
        check_out("R9 master on");

        // R11: idle cycles hold ident
        repeat (3) @(negedge clk);
        check_out("R11 idle hold");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule